// File: doc/BRIEF.md
# Infrared Remote Frame Receiver

This block turns the demodulated output of an infrared receiver module into a 32-bit remote-control frame. The input is active low: a low level means a carrier burst is present, and a high level means the line is quiet. The block brings the input into its clock domain through two flops. It measures how long each burst and each gap lasts with a counter that restarts on every edge. A small state machine steps through four states: waiting, leader burst, leader gap, and payload capture.

A frame opens with a long leader burst and a shorter gap. Thirty-two bits follow. Each bit is a short burst and then a gap, and the length of the gap gives the bit's value. Bits arrive least significant first. The first sixteen form a custom code, the next eight a key code, and the last eight the bitwise inverse of that key code. The frame is taken only when the key code and its inverse agree. In that case the block raises a one-cycle strobe and loads the new fields into held outputs. The custom code is presented as two bytes so that each byte can drive its own display.

All timing scales with a single parameter, `UNIT_TICKS`, the number of clock cycles in one 562.5 us unit. The nominal durations are 16 units for the leader burst, 8 units for the leader gap, 1 unit for a 0-gap and 3 units for a 1-gap. Every window is widened on both sides by `TOL_PCT` percent, which defaults to 20. Bounds are computed in integer arithmetic as nominal*(100-TOL)/100 and nominal*(100+TOL)/100.

Top module: `ir_frame_rx`

## Requirements
- R1: While reset is active and after it is released, `frame_valid` is 0 and all four held byte outputs are 0 until the first accepted frame.
- R2: Payload capture starts only after a leader burst whose length lies in the window around 16 units (128..192 cycles at 10 ticks per unit) and a leader gap whose length lies in the window around 8 units (64..96 cycles). A leader outside either window produces no strobe and leaves the held outputs unchanged.
- R3: A gap in the window around 1 unit (8..12 cycles at 10 ticks per unit) decodes as 0. A gap in the window around 3 units (24..36 cycles) decodes as 1. A gap outside both windows abandons the frame.
- R4: Bits shift in least significant first. Received bit i (counting from 0) lands in bit i of the 32-bit word. Word bits 15..0 are the custom code, bits 23..16 the key code, and bits 31..24 the inverted key code.
- R5: A completed frame is accepted only when key code XOR inverted key code equals 8'hFF. Any other completed frame produces no strobe and leaves the held outputs unchanged.
- R6: `frame_valid` is high for exactly one cycle per accepted frame. The held outputs change only in that cycle.
- R7: While capturing the payload, a burst or gap that lasts longer than 9 units (more than 90 cycles at 10 ticks per unit) abandons the partial frame. A new frame sent afterwards decodes in full.
- R8: `custom_hi` carries custom code bits 15..8 and `custom_lo` carries bits 7..0.
- R9: `frame_valid` rises on the third rising clock edge after the input falls at the start of the burst that ends the 32nd gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_rx_n | input | 1 | Demodulated receiver output, low while a burst is present |
| frame_valid | output | 1 | One-cycle strobe when a frame is accepted |
| custom_hi | output | 8 | Held custom code, upper byte |
| custom_lo | output | 8 | Held custom code, lower byte |
| key_code | output | 8 | Held key code |
| key_code_n | output | 8 | Held inverted key code |

## Verification
The properties assume the input comes from a demodulator: it stays at one level for many clocks between edges, so the strobe cannot repeat within a frame length, and a new frame never begins until the previous one has ended. The stimulus follows that assumption. It changes the input only on falling clock edges, holds each level for a whole number of cycles, and always puts an idle gap of tens of cycles between frames. The timing sweeps move only one width at a time onto or just past a window edge, so each rejection can be traced to a single rule.

// File: rtl/ir_frame_rx.sv
module ir_frame_rx #(
  parameter int UNIT_TICKS = 28125,
  parameter int TOL_PCT    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_rx_n,
  output logic       frame_valid,
  output logic [7:0] custom_hi,
  output logic [7:0] custom_lo,
  output logic [7:0] key_code,
  output logic [7:0] key_code_n
);
  localparam int LM_NOM  = 16 * UNIT_TICKS;
  localparam int LS_NOM  = 8 * UNIT_TICKS;
  localparam int S0_NOM  = UNIT_TICKS;
  localparam int S1_NOM  = 3 * UNIT_TICKS;
  localparam int GAP_LIM = 9 * UNIT_TICKS;
  localparam int LM_LO   = LM_NOM * (100 - TOL_PCT) / 100;
  localparam int LM_HI   = LM_NOM * (100 + TOL_PCT) / 100;
  localparam int LS_LO   = LS_NOM * (100 - TOL_PCT) / 100;
  localparam int LS_HI   = LS_NOM * (100 + TOL_PCT) / 100;
  localparam int S0_LO   = S0_NOM * (100 - TOL_PCT) / 100;
  localparam int S0_HI   = S0_NOM * (100 + TOL_PCT) / 100;
  localparam int S1_LO   = S1_NOM * (100 - TOL_PCT) / 100;
  localparam int S1_HI   = S1_NOM * (100 + TOL_PCT) / 100;
  localparam int CNT_TOP = ((LM_HI > GAP_LIM) ? LM_HI : GAP_LIM) + 1;
  localparam int CW      = $clog2(CNT_TOP + 1);

  localparam logic [CW-1:0] LM_LO_C  = CW'(LM_LO);
  localparam logic [CW-1:0] LM_HI_C  = CW'(LM_HI);
  localparam logic [CW-1:0] LS_LO_C  = CW'(LS_LO);
  localparam logic [CW-1:0] LS_HI_C  = CW'(LS_HI);
  localparam logic [CW-1:0] S0_LO_C  = CW'(S0_LO);
  localparam logic [CW-1:0] S0_HI_C  = CW'(S0_HI);
  localparam logic [CW-1:0] S1_LO_C  = CW'(S1_LO);
  localparam logic [CW-1:0] S1_HI_C  = CW'(S1_HI);
  localparam logic [CW-1:0] GAP_C    = CW'(GAP_LIM);
  localparam logic [CW-1:0] CNT_TOPC = CW'(CNT_TOP);

  typedef enum logic [1:0] {S_IDLE, S_LMARK, S_LSPACE, S_DATA} state_t;

  state_t          state;
  logic [1:0]      sync_q;
  logic            mark_q;
  logic [CW-1:0]   cnt;
  logic [4:0]      bit_cnt;
  logic [31:0]     shreg;
  logic [31:0]     held_q;

  wire mark      = ~sync_q[1];
  wire edge_seen = mark ^ mark_q;

  function automatic logic in_win(input logic [CW-1:0] v, input logic [CW-1:0] lo,
                                  input logic [CW-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  wire        is_zero   = in_win(cnt, S0_LO_C, S0_HI_C);
  wire        is_one    = in_win(cnt, S1_LO_C, S1_HI_C);
  wire [31:0] next_word = {is_one, shreg[31:1]};
  wire        inv_ok    = (next_word[23:16] ^ next_word[31:24]) == 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      mark_q <= 1'b0;
      cnt    <= '0;
    end else begin
      sync_q <= {sync_q[0], ir_rx_n};
      mark_q <= mark;
      if (edge_seen)             cnt <= CW'(1);
      else if (cnt != CNT_TOPC)  cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      held_q      <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (edge_seen && mark) state <= S_LMARK;
        S_LMARK:
          if (edge_seen)
            state <= in_win(cnt, LM_LO_C, LM_HI_C) ? S_LSPACE : S_IDLE;
          else if (cnt > LM_HI_C)
            state <= S_IDLE;
        S_LSPACE:
          if (edge_seen) begin
            if (in_win(cnt, LS_LO_C, LS_HI_C)) begin
              state   <= S_DATA;
              bit_cnt <= '0;
            end else begin
              state <= S_IDLE;
            end
          end else if (cnt > LS_HI_C) begin
            state <= S_IDLE;
          end
        S_DATA:
          if (edge_seen && mark) begin
            if (is_zero || is_one) begin
              shreg   <= next_word;
              bit_cnt <= bit_cnt + 5'd1;
              if (bit_cnt == 5'd31) begin
                state <= S_IDLE;
                if (inv_ok) begin
                  frame_valid <= 1'b1;
                  held_q      <= next_word;
                end
              end
            end else begin
              state <= S_IDLE;
            end
          end else if (!edge_seen && cnt > GAP_C) begin
            state <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign custom_hi  = held_q[15:8];
  assign custom_lo  = held_q[7:0];
  assign key_code   = held_q[23:16];
  assign key_code_n = held_q[31:24];
endmodule

// File: rtl/ir_frame_rx_chk.sv
module ir_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_valid,
  input logic [7:0] custom_hi,
  input logic [7:0] custom_lo,
  input logic [7:0] key_code,
  input logic [7:0] key_code_n,
  input logic [1:0] state
);
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  p_hold_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({custom_hi, custom_lo, key_code, key_code_n}) |-> frame_valid);

  p_inverse_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ((key_code ^ key_code_n) == 8'hFF));

  p_idle_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (state == 2'd0));

  p_idle_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |=> (state == 2'd0 || state == 2'd1));

  p_data_after_leader_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 2'd3) && ($past(state) != 2'd3)) |-> ($past(state) == 2'd2));
endmodule

bind ir_frame_rx ir_frame_rx_chk chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .frame_valid(frame_valid),
  .custom_hi(custom_hi),
  .custom_lo(custom_lo),
  .key_code(key_code),
  .key_code_n(key_code_n),
  .state(state)
);

// File: tb/ir_frame_rx_tb.sv
`timescale 1ns/1ps
module ir_frame_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_rx_n = 1'b1;
  logic       frame_valid;
  logic [7:0] custom_hi, custom_lo, key_code, key_code_n;

  int checks = 0;
  int failures = 0;
  int strobes = 0;
  int good_frames = 0;
  bit done = 1'b0;
  logic [31:0] held_exp = '0;

  always #2 clk = ~clk;

  ir_frame_rx #(.UNIT_TICKS(10), .TOL_PCT(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .ir_rx_n(ir_rx_n), .frame_valid(frame_valid),
    .custom_hi(custom_hi), .custom_lo(custom_lo),
    .key_code(key_code), .key_code_n(key_code_n)
  );

  always @(negedge clk) if (rst_n && frame_valid) strobes++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int n);
    ir_rx_n = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_held(input string req);
    chk({key_code_n, key_code, custom_hi, custom_lo} == held_exp, req,
        {key_code_n, key_code, custom_hi, custom_lo}, held_exp);
  endtask

  task automatic send_frame(input logic [15:0] cust, input logic [7:0] key,
                            input logic [7:0] inv, input int lm, input int ls,
                            input int s0, input int s1, input int bad_idx,
                            input int bad_sp, input bit expect_ok, input string req);
    logic [31:0] w;
    w = {inv, key, cust};
    drive(1'b0, lm);
    drive(1'b1, ls);
    for (int i = 0; i < 32; i++) begin
      drive(1'b0, 10);
      drive(1'b1, (i == bad_idx) ? bad_sp : (w[i] ? s1 : s0));
    end
    ir_rx_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(frame_valid == 1'b0, "R9 no strobe after two edges", {31'd0, frame_valid}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    if (expect_ok) begin
      chk(frame_valid == 1'b1, {req, " R9 strobe on third edge"}, {31'd0, frame_valid}, 32'd1);
      held_exp = w;
      good_frames++;
      check_held({req, " R4 field order"});
      chk(custom_hi == cust[15:8], "R8 custom_hi", {24'd0, custom_hi}, {24'd0, cust[15:8]});
      chk(custom_lo == cust[7:0], "R8 custom_lo", {24'd0, custom_lo}, {24'd0, cust[7:0]});
    end else begin
      chk(frame_valid == 1'b0, {req, " rejected"}, {31'd0, frame_valid}, 32'd0);
      check_held({req, " held unchanged"});
    end
    @(negedge clk);
    chk(frame_valid == 1'b0, "R6 single-cycle strobe", {31'd0, frame_valid}, 32'd0);
    drive(1'b0, 8);
    drive(1'b1, 60);
  endtask

  task automatic good(input logic [15:0] c, input logic [7:0] k, input string req);
    send_frame(c, k, ~k, 160, 80, 10, 30, -1, 0, 1'b1, req);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(frame_valid == 1'b0, "R1 strobe low in reset", {31'd0, frame_valid}, 32'd0);
    check_held("R1 held zero in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(frame_valid == 1'b0, "R1 strobe low after reset", {31'd0, frame_valid}, 32'd0);
    check_held("R1 held zero after reset");

    good(16'h0000, 8'h00, "R4 zeros");
    good(16'hFFFF, 8'hFF, "R4 ones");
    good(16'hA5C3, 8'h5A, "R4 mixed");
    good(16'h0001, 8'h80, "R4 lsb first");
    for (int k = 0; k < 16; k++)
      good(16'(k * 16'h1357) ^ 16'hA0A0, 8'(k * 37 + 1), "R4 sweep");

    send_frame(16'h1234, 8'h21, 8'hDE, 128, 80, 10, 30, -1, 0, 1'b1, "R2 leader burst min");
    send_frame(16'h2345, 8'h32, 8'hCD, 192, 80, 10, 30, -1, 0, 1'b1, "R2 leader burst max");
    send_frame(16'h3456, 8'h43, 8'hBC, 127, 80, 10, 30, -1, 0, 1'b0, "R2 leader burst short");
    send_frame(16'h4567, 8'h54, 8'hAB, 193, 80, 10, 30, -1, 0, 1'b0, "R2 leader burst long");
    send_frame(16'h5678, 8'h65, 8'h9A, 160, 64, 10, 30, -1, 0, 1'b1, "R2 leader gap min");
    send_frame(16'h6789, 8'h76, 8'h89, 160, 96, 10, 30, -1, 0, 1'b1, "R2 leader gap max");
    send_frame(16'h789A, 8'h87, 8'h78, 160, 63, 10, 30, -1, 0, 1'b0, "R2 leader gap short");
    send_frame(16'h89AB, 8'h98, 8'h67, 160, 97, 10, 30, -1, 0, 1'b0, "R2 leader gap long");

    send_frame(16'hC35A, 8'h3C, 8'hC3, 160, 80, 8, 24, -1, 0, 1'b1, "R3 lower bit windows");
    send_frame(16'h5AC3, 8'hC3, 8'h3C, 160, 80, 12, 36, -1, 0, 1'b1, "R3 upper bit windows");
    send_frame(16'h1111, 8'h22, 8'hDD, 160, 80, 10, 30, 5, 7, 1'b0, "R3 gap below zero window");
    send_frame(16'h1111, 8'h22, 8'hDD, 160, 80, 10, 30, 5, 13, 1'b0, "R3 gap above zero window");
    send_frame(16'h1111, 8'h22, 8'hDD, 160, 80, 10, 30, 5, 23, 1'b0, "R3 gap below one window");
    send_frame(16'h1111, 8'h22, 8'hDD, 160, 80, 10, 30, 5, 37, 1'b0, "R3 gap above one window");

    send_frame(16'hBEEF, 8'h12, 8'h12, 160, 80, 10, 30, -1, 0, 1'b0, "R5 inverse equal");
    send_frame(16'hBEEF, 8'h12, 8'hEC, 160, 80, 10, 30, -1, 0, 1'b0, "R5 inverse off by one bit");

    send_frame(16'hCAFE, 8'h44, 8'hBB, 160, 80, 10, 30, 10, 100, 1'b0, "R7 gap timeout");
    good(16'hF00D, 8'h66, "R7 frame after timeout");
    send_frame(16'hCAFE, 8'h44, 8'hBB, 160, 80, 10, 30, 31, 100, 1'b0, "R7 timeout on last bit");
    good(16'h0F0F, 8'h99, "R7 frame after late timeout");

    chk(strobes == good_frames, "R6 one strobe per accepted frame", 32'(strobes), 32'(good_frames));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule